// File: doc/BRIEF.md
# Switch Debouncer with Rising-Edge Pulse

This block filters the bouncing level of one mechanical switch into a clean, debounced level and a single-cycle pulse that marks each accepted low-to-high change. The switch input is expected to be synchronous to the block clock already. The design is a four-state control machine that steers one down-counter. The states are stable low, confirming high, stable high and confirming low.

A change of the switch is accepted only after the input has held the new value for a full counter period. The counter is reloaded to all ones when the machine enters a confirming state. It then decrements on every cycle in which the input keeps the new value. The expiry test looks at the decremented value before it is stored, so no extra cycle is spent. Any reversion during the confirming wait abandons the change.

With the default 21-bit counter and a 50 MHz clock, the confirmation interval is about 42 ms. The counter width is a parameter, so a small configuration can be checked cycle by cycle.

Top module: `sw_debounce`

## Requirements
- R1: While `rst_n` is low, `level_o` and `rise_tick_o` are 0 at once, without waiting for a clock edge. After `rst_n` rises, the block stays in reset for two more clock edges, because the release is synchronised.
- R2: From stable low, the debounced level rises after 2^CNT_W consecutive rising-edge samples of `sw_i` = 1. `level_o` reads 1 in the cycle that follows the last of those samples.
- R3: `rise_tick_o` is 1 for exactly one cycle per accepted rise. That cycle is the one whose edge takes the last confirming sample, and `level_o` is still 0 during it. `level_o` is 1 in the next cycle.
- R4: A run of 1s shorter than 2^CNT_W samples leaves `level_o` at 0 and produces no tick. This includes a run that breaks in the very cycle the count would expire.
- R5: From stable high, the debounced level falls after 2^CNT_W consecutive samples of `sw_i` = 0. `level_o` reads 0 in the cycle that follows the last of those samples.
- R6: A run of 0s shorter than 2^CNT_W samples leaves `level_o` at 1.
- R7: `rise_tick_o` is never 1 on a falling change, while the level is stable, or while `sw_i` is 0.
- R8: The level changes only in the cycle after the counter holds 1 and is decremented to 0. When the input equals the debounced level, the level holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| sw_i | input | 1 | Raw switch level, already synchronous to clk |
| level_o | output | 1 | Debounced switch level |
| rise_tick_o | output | 1 | One-cycle pulse on each accepted low-to-high change |

## Verification
The assertions assume that `sw_i` is synchronous to `clk` and settles between edges. Under that assumption, each edge samples one clean value, and the stable-hold and one-cycle-pulse properties can be stated edge by edge. The bench changes `sw_i` one nanosecond after a rising edge and holds it for the whole cycle. It keeps `sw_i` low while the reset release passes through the synchroniser, so no confirming count can start during the two cycles when the block still ignores its input.

// File: rtl/sw_debounce_pkg.sv
package sw_debounce_pkg;

  typedef enum logic [1:0] {
    ST_LOW  = 2'd0,
    ST_RISE = 2'd1,
    ST_HIGH = 2'd2,
    ST_FALL = 2'd3
  } deb_state_e;

endpackage

// File: rtl/deb_rst_sync.sv
module deb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/deb_down_counter.sv
module deb_down_counter #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dec_zero_o
);

  localparam logic [CNT_W-1:0] CNT_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_dec;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // The decremented value is formed combinationally so the controller
  // can test for expiry in the same cycle it is produced.
  assign cnt_dec    = cnt_q - CNT_ONE;
  assign dec_zero_o = (cnt_dec == '0);

  always_comb begin
    cnt_en = load_i | dec_i;
    if (load_i) begin
      cnt_d = CNT_ONES;
    end else begin
      cnt_d = cnt_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/deb_ctrl_fsm.sv
module deb_ctrl_fsm
  import sw_debounce_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_i,
  input  logic       dec_zero_i,
  output logic       load_o,
  output logic       dec_o,
  output logic       level_o,
  output logic       tick_o,
  output deb_state_e state_o
);

  deb_state_e state_q;
  deb_state_e state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    dec_o   = 1'b0;
    tick_o  = 1'b0;
    unique case (state_q)
      ST_LOW: begin
        if (sw_i) begin
          state_d = ST_RISE;
          load_o  = 1'b1;
        end
      end
      ST_RISE: begin
        if (!sw_i) begin
          state_d = ST_LOW;
        end else begin
          dec_o = 1'b1;
          if (dec_zero_i) begin
            state_d = ST_HIGH;
            tick_o  = 1'b1;
          end
        end
      end
      ST_HIGH: begin
        if (!sw_i) begin
          state_d = ST_FALL;
          load_o  = 1'b1;
        end
      end
      ST_FALL: begin
        if (sw_i) begin
          state_d = ST_HIGH;
        end else begin
          dec_o = 1'b1;
          if (dec_zero_i) begin
            state_d = ST_LOW;
          end
        end
      end
      default: begin
        state_d = ST_LOW;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOW;
    end else begin
      state_q <= state_d;
    end
  end

  assign level_o = (state_q == ST_HIGH) || (state_q == ST_FALL);
  assign state_o = state_q;

endmodule

// File: rtl/sw_debounce.sv
module sw_debounce
  import sw_debounce_pkg::*;
#(
  parameter int CNT_W = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_i,
  output logic level_o,
  output logic rise_tick_o
);

  localparam int RST_STAGES = 2;

  logic             rst_int_n;
  logic             cnt_load;
  logic             cnt_dec;
  logic             cnt_zero;
  logic [CNT_W-1:0] cnt_q;
  deb_state_e       state_q;

  deb_rst_sync #(
    .STAGES(RST_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  deb_ctrl_fsm u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sw_i      (sw_i),
    .dec_zero_i(cnt_zero),
    .load_o    (cnt_load),
    .dec_o     (cnt_dec),
    .level_o   (level_o),
    .tick_o    (rise_tick_o),
    .state_o   (state_q)
  );

  deb_down_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (cnt_load),
    .dec_i     (cnt_dec),
    .cnt_o     (cnt_q),
    .dec_zero_o(cnt_zero)
  );

endmodule

// File: rtl/sw_debounce_chk.sv
module sw_debounce_chk #(
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_i,
  input logic             level_o,
  input logic             rise_tick_o,
  input logic [CNT_W-1:0] cnt_q
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!level_o && !rise_tick_o));

  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick_o |=> !rise_tick_o);

  // R3
  tick_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick_o |-> (!level_o ##1 level_o));

  // R2
  rise_has_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_o) |-> $past(rise_tick_o));

  // R7
  tick_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick_o |-> sw_i);

  // R8
  rise_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_o) |-> ($past(cnt_q) == CNT_W'(1)));

  // R5
  fall_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(level_o) |-> (($past(cnt_q) == CNT_W'(1)) && !$past(sw_i)));

  // R4
  low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_i && !level_o) |=> !level_o);

  // R6
  high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_i && level_o) |=> level_o);

endmodule

bind sw_debounce sw_debounce_chk #(
  .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_i       (sw_i),
  .level_o    (level_o),
  .rise_tick_o(rise_tick_o),
  .cnt_q      (cnt_q)
);

// File: tb/tb_sw_debounce.sv
module tb_sw_debounce;

  localparam int CNT_W = 4;
  localparam int CONF  = 1 << CNT_W;

  logic clk;
  logic rst_n;
  logic sw_i;
  logic level_o;
  logic rise_tick_o;

  int checks;
  int fails;
  bit done;

  // bench model of the requirements
  bit exp_level;
  int run_len;

  sw_debounce #(
    .CNT_W(CNT_W)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_i       (sw_i),
    .level_o    (level_o),
    .rise_tick_o(rise_tick_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called just after a rising edge. Drives sw_i for one cycle, checks the
  // outputs mid-cycle, then advances the model at the next rising edge.
  task automatic step(input bit v, input string req);
    bit exp_tick;
    sw_i = v;
    @(negedge clk);
    exp_tick = !exp_level && v && (run_len == CONF - 1);
    check(level_o == exp_level, req, "level", int'(level_o), int'(exp_level));
    check(rise_tick_o == exp_tick, exp_tick ? "R3" : "R7", "tick",
          int'(rise_tick_o), int'(exp_tick));
    @(posedge clk);
    if (v != exp_level) begin
      if (run_len == CONF - 1) begin
        exp_level = v;
        run_len   = 0;
      end else begin
        run_len++;
      end
    end else begin
      run_len = 0;
    end
    #1;
  endtask

  task automatic hold(input bit v, input int n, input string req);
    for (int i = 0; i < n; i++) step(v, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sw_i  = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(level_o == 1'b0, "R1", "reset level", int'(level_o), 0);
    check(rise_tick_o == 1'b0, "R1", "reset tick", int'(rise_tick_o), 0);
    rst_n     = 1'b1;
    exp_level = 1'b0;
    run_len   = 0;
    @(posedge clk);
    #1;
    hold(1'b0, 3, "R1");
  endtask

  initial begin
    bit [15:0] lfsr;
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    sw_i   = 1'b0;
    do_reset();

    // R2 R3: exact-length rise, then stable high
    hold(1'b1, CONF + 4, "R2");

    // R6: every short falling run, lengths 1 .. CONF-1
    for (int len = 1; len < CONF; len++) begin
      hold(1'b0, len, "R6");
      hold(1'b1, 3, "R6");
    end

    // R5: exact-length fall
    hold(1'b0, CONF + 3, "R5");

    // R4: every short rising run, including one that breaks at expiry
    for (int len = 1; len < CONF; len++) begin
      hold(1'b1, len, "R4");
      hold(1'b0, 3, "R4");
    end

    // R8: back-to-back change with no stable gap
    hold(1'b1, CONF, "R8");
    hold(1'b0, CONF, "R8");
    hold(1'b0, 2, "R8");

    // R2 R5: bounce bursts followed by a settled level
    for (int b = 0; b < 6; b++) begin
      hold(1'b1, 1 + b, "R2");
      hold(1'b0, 1, "R2");
    end
    hold(1'b1, CONF + 2, "R2");
    for (int b = 0; b < 6; b++) begin
      hold(1'b0, 2 + b, "R5");
      hold(1'b1, 1, "R5");
    end
    hold(1'b0, CONF + 2, "R5");

    // R7: pseudo-random runs of mixed lengths
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      int len;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      len  = 1 + int'(lfsr[4:0]);
      hold(lfsr[7], len, "R7");
    end

    // R1: asynchronous reset while the level is high
    hold(1'b1, CONF + 2, "R1");
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check(level_o == 1'b0, "R1", "async reset level", int'(level_o), 0);
    check(rise_tick_o == 1'b0, "R1", "async reset tick", int'(rise_tick_o), 0);
    do_reset();
    hold(1'b1, CONF + 2, "R2");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule